// File: doc/BRIEF.md
# Adaptive JTAG Clock Synchronizer

This block lives inside a core that supports adaptive test clocking. The debugger drives the test clock, mode select and data input asynchronously to the core. Each of the three signals passes through its own chain of flip-flops clocked by the core clock. All three chains have the same depth, set by `SYNC_STAGES`. The output of the last stage of the test-clock chain is driven straight back out as the return clock.

The debugger treats the return clock as a handshake. It issues the next test-clock edge only after it sees the previous edge echoed on the return clock. The test-clock rate therefore follows the core clock rate. The highest rate the block can follow is the core clock frequency divided by twice the chain depth. For example, a 192 MHz core with three stages allows 32 MHz. If the test clock toggles faster than this, the return clock drops edges.

For the TAP controller that follows, the block produces two one-cycle strobes in the core domain: one for the rising edge and one for the falling edge of the synchronized test clock. It also presents mode-select and data samples taken from the same chain stage as the clock edge. The TAP state machine, the scan chains and the pads lie outside this block.

Top module: `adj_tck_sync`

## Requirements
- R1: While `rst_ni` is low, `rtck_o`, `tck_rise_o`, `tck_fall_o`, `tms_o` and `tdi_o` are all 0, whatever the JTAG inputs do.
- R2: After `tck_i` changes, `rtck_o` shows the new level exactly `SYNC_STAGES` core clock edges later, counting the first edge that samples the change.
- R3: A 0-to-1 transition of `tck_i` yields exactly one `tck_rise_o` pulse, one core cycle wide, in the cycle after `rtck_o` goes high (edge `SYNC_STAGES`+1 after the change).
- R4: A 1-to-0 transition of `tck_i` yields exactly one `tck_fall_o` pulse, one core cycle wide, in the cycle after `rtck_o` goes low.
- R5: `tck_rise_o` and `tck_fall_o` are never high in the same cycle, and neither stays high for two cycles in a row.
- R6: While `tck_rise_o` is high, `tms_o` and `tdi_o` equal the levels `tms_i` and `tdi_i` had when the core clock sampled the rising test-clock edge.
- R7: Every transition of `rtck_o` produces exactly one strobe, and no strobe appears without one. When each test-clock half-period lasts at least `SYNC_STAGES` core cycles, every test-clock edge is echoed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tck_i | input | 1 | Test clock from the debugger, asynchronous |
| tms_i | input | 1 | Test mode select from the debugger, asynchronous |
| tdi_i | input | 1 | Test data in from the debugger, asynchronous |
| rtck_o | output | 1 | Return clock, last stage of the test-clock chain |
| tck_rise_o | output | 1 | One-cycle strobe on a synchronized rising edge |
| tck_fall_o | output | 1 | One-cycle strobe on a synchronized falling edge |
| tms_o | output | 1 | Synchronized mode select, aligned with the strobes |
| tdi_o | output | 1 | Synchronized data in, aligned with the strobes |

## Verification
The bench drives the test clock at the highest rate the block can follow, with a half-period of exactly `SYNC_STAGES` core cycles, and also at slower and asymmetric rates. It changes mode select and data in the same cycle as the clock edge. A design whose data chains were one stage off from the clock chain would present a stale `tms_o` or `tdi_o` with the rise strobe. A design with the wrong chain depth would show the return clock or the strobes a cycle early or late. Two further cases cover reset. Test-clock activity during reset must not leak a return edge. A reset asserted while the chain holds ones must not leave behind a phantom falling strobe, and a design that skipped clearing the edge history would emit one.

// File: rtl/adj_pkg.sv
package adj_pkg;
  localparam int unsigned DEF_SYNC_STAGES = 3;

  typedef struct packed {
    logic tck;
    logic tms;
    logic tdi;
  } jtag_bits_t;

  localparam int unsigned JTAG_W = $bits(jtag_bits_t);
endpackage

// File: rtl/adj_sync_chain.sv
module adj_sync_chain #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q <= '0;
      else         stage_q <= d_i;
    end
  end else begin : g_multi
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q <= '0;
      else         stage_q <= {stage_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = stage_q[LAST];
endmodule

// File: rtl/adj_edge_det.sv
module adj_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic tms_i,
  input  logic tdi_i,
  output logic rise_o,
  output logic fall_o,
  output logic tms_o,
  output logic tdi_o
);
  logic prev_q;
  logic rise_q, fall_q;
  logic tms_q, tdi_q;

  // all outputs registered together so strobe and data stay in step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      tms_q  <= 1'b0;
      tdi_q  <= 1'b0;
    end else begin
      prev_q <= level_i;
      rise_q <= level_i & ~prev_q;
      fall_q <= ~level_i & prev_q;
      tms_q  <= tms_i;
      tdi_q  <= tdi_i;
    end
  end

  assign rise_o = rise_q;
  assign fall_o = fall_q;
  assign tms_o  = tms_q;
  assign tdi_o  = tdi_q;
endmodule

// File: rtl/adj_tck_sync.sv
module adj_tck_sync
  import adj_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tck_i,
  input  logic tms_i,
  input  logic tdi_i,
  output logic rtck_o,
  output logic tck_rise_o,
  output logic tck_fall_o,
  output logic tms_o,
  output logic tdi_o
);
  jtag_bits_t raw_in;
  jtag_bits_t sync_out;

  assign raw_in.tck = tck_i;
  assign raw_in.tms = tms_i;
  assign raw_in.tdi = tdi_i;

  // one chain of equal depth for all three lines keeps them aligned
  adj_sync_chain #(
    .WIDTH  (JTAG_W),
    .STAGES (SYNC_STAGES)
  ) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_in),
    .q_o    (sync_out)
  );

  assign rtck_o = sync_out.tck;

  adj_edge_det u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (sync_out.tck),
    .tms_i   (sync_out.tms),
    .tdi_i   (sync_out.tdi),
    .rise_o  (tck_rise_o),
    .fall_o  (tck_fall_o),
    .tms_o   (tms_o),
    .tdi_o   (tdi_o)
  );
endmodule

// File: rtl/adj_tck_sync_chk.sv
module adj_tck_sync_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rtck_o,
  input logic tck_rise_o,
  input logic tck_fall_o,
  input logic tms_o,
  input logic tdi_o
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (!rtck_o && !tck_rise_o && !tck_fall_o && !tms_o && !tdi_o);
    end
  end

  // R3
  rise_after_rtck_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tck_rise_o |-> ($past(rtck_o) && !$past(rtck_o, 2)));

  // R4
  fall_after_rtck_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tck_fall_o |-> (!$past(rtck_o) && $past(rtck_o, 2)));

  // R5
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tck_rise_o && tck_fall_o));

  // R5
  rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tck_rise_o |=> !tck_rise_o);

  // R5
  fall_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tck_fall_o |=> !tck_fall_o);

  // R7
  rtck_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rtck_o != $past(rtck_o)) |=> (tck_rise_o || tck_fall_o));
endmodule

bind adj_tck_sync adj_tck_sync_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rtck_o     (rtck_o),
  .tck_rise_o (tck_rise_o),
  .tck_fall_o (tck_fall_o),
  .tms_o      (tms_o),
  .tdi_o      (tdi_o)
);

// File: tb/adj_tck_sync_test.sv
module adj_tck_sync_test;
  localparam int NS = 3;

  typedef struct {
    int   due;
    logic rise;
    logic tms;
    logic tdi;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tck = 1'b0, tms = 1'b0, tdi = 1'b0;
  logic rtck, rise, fall, tms_s, tdi_s;

  int   cyc = 0;
  int   total = 0;
  int   bad = 0;
  logic cur_tck = 1'b0;
  logic done = 1'b0;
  exp_t exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adj_tck_sync #(.SYNC_STAGES(NS)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .tck_i      (tck),
    .tms_i      (tms),
    .tdi_i      (tdi),
    .rtck_o     (rtck),
    .tck_rise_o (rise),
    .tck_fall_o (fall),
    .tms_o      (tms_s),
    .tdi_o      (tdi_s)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: applies one input step and queues the expected strobe
  task automatic drive(input logic lvl, input logic m, input logic d);
    exp_t e;
    @(negedge clk);
    tck = lvl; tms = m; tdi = d;
    if (lvl != cur_tck) begin
      e.due = cyc + NS + 1; e.rise = lvl; e.tms = m; e.tdi = d;
      exp_q.push_back(e);
    end
    cur_tck = lvl;
  endtask

  task automatic run_clock(input int hi, input int lo, input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      drive(1'b1, logic'((seed >> (i % 7)) & 1), logic'(((seed * 3) >> (i % 5)) & 1));
      wait_cyc(hi - 1);
      drive(1'b0, logic'(~(seed >> (i % 3)) & 1), logic'((seed >> (i % 4)) & 1));
      wait_cyc(lo - 1);
    end
  endtask

  // monitor: pops expected strobes as the design produces them
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rise || fall) begin
        check(!(rise && fall), "R5 both strobes", 1, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected strobe", int'(rise), 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(cyc == e.due, e.rise ? "R3 rise cycle" : "R4 fall cycle", cyc, e.due);
          check(rise == e.rise, "R7 strobe kind", int'(rise), int'(e.rise));
          check(rtck == e.rise, "R2 rtck level at strobe", int'(rtck), int'(e.rise));
          if (e.rise) begin
            check(tms_s == e.tms, "R6 tms with rise", int'(tms_s), int'(e.tms));
            check(tdi_s == e.tdi, "R6 tdi with rise", int'(tdi_s), int'(e.tdi));
          end
        end
      end else if (exp_q.size() > 0 && cyc > exp_q[0].due) begin
        check(1'b0, "R7 missing strobe", cyc, exp_q[0].due);
        void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c0;
    // R1: reset state, with JTAG activity during reset
    wait_cyc(3);
    check({rtck, rise, fall, tms_s, tdi_s} == 5'b0, "R1 reset outputs", {rtck, rise, fall, tms_s, tdi_s}, 0);
    tck = 1'b1; tms = 1'b1; tdi = 1'b1;
    wait_cyc(NS + 3);
    check({rtck, rise, fall, tms_s, tdi_s} == 5'b0, "R1 inputs ignored in reset", {rtck, rise, fall, tms_s, tdi_s}, 0);
    tck = 1'b0; tms = 1'b0; tdi = 1'b0;
    wait_cyc(NS + 2);
    rst_n = 1'b1;
    wait_cyc(4);

    // R2: exact return-clock latency
    @(negedge clk);
    c0 = cyc;
    tck = 1'b1; tms = 1'b1; tdi = 1'b0; cur_tck = 1'b1;
    begin
      exp_t e;
      e.due = c0 + NS + 1; e.rise = 1'b1; e.tms = 1'b1; e.tdi = 1'b0;
      exp_q.push_back(e);
    end
    wait_cyc(NS - 1);
    check(rtck == 1'b0, "R2 rtck before latency", int'(rtck), 0);
    wait_cyc(1);
    check(rtck == 1'b1, "R2 rtck after latency", int'(rtck), 1);
    wait_cyc(4);
    drive(1'b0, 1'b0, 1'b1);
    wait_cyc(NS + 4);

    // R7: maximum rate, half-period equal to chain depth
    run_clock(NS, NS, 10, 37);
    // slower and asymmetric rates
    run_clock(5, 7, 6, 91);
    run_clock(NS, 9, 5, 22);
    run_clock(11, NS, 5, 105);
    wait_cyc(NS + 6);
    check(exp_q.size() == 0, "R7 all edges echoed", exp_q.size(), 0);

    // R1: reset while chain holds ones
    drive(1'b1, 1'b1, 1'b1);
    wait_cyc(NS + 6);
    @(negedge clk);
    rst_n = 1'b0;
    wait_cyc(1);
    check({rtck, rise, fall, tms_s, tdi_s} == 5'b0, "R1 mid-run reset clears", {rtck, rise, fall, tms_s, tdi_s}, 0);
    tck = 1'b0; tms = 1'b0; tdi = 1'b0; cur_tck = 1'b0;
    wait_cyc(2);
    rst_n = 1'b1;
    wait_cyc(NS + 6);
    check(exp_q.size() == 0 && rtck == 1'b0, "R7 no phantom edge after reset", int'(rtck), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule